// File: doc/BRIEF.md
# I2C EEPROM byte-access master

This block is a single-master two-wire bus controller. It performs one-byte transactions on a small serial EEPROM. A user request either writes one byte at a 9-bit address or reads one byte back from such an address.

A write sends the device select, then the low address byte, then the data byte. A read first performs a dummy write of the address. It then issues a repeated START, selects the device for reading, shifts in eight bits and returns them. Bit 8 of the address selects the upper half of the memory. That bit is driven on a separate chip-enable output and is not folded into the select byte.

Every bus edge is paced by a reloadable tick timer whose count is programmed from the user side. Any missing acknowledge ends the attempt with a STOP, and the whole transaction restarts from a fresh START. After four failed attempts the block gives up and reports an error with its done pulse.

The sequencer is one state machine. Its states and transitions are as follows:

- **Idle and start.**
  - `S_IDLE` waits with the bus free.
  - A request moves it to `S_STA1`, which holds SCL low with SDA high.
  - Each tick then advances it through `S_STA2` (SCL high), `S_STA3` (SDA low, the START) and `S_STA4` (SCL low).
- **Bit cycle.** Each bit takes three phases: `S_BLO` (data set up), `S_BHI` (SCL high, sampling) and `S_BHOLD` (SCL low, data held).
- **After the ninth bit, `S_BHOLD` moves to one of:**
  - `S_BLO` for the next byte;
  - `S_STA1` for the repeated START of a read;
  - `S_STP1` when the last byte is done or a NACK was seen.
- **Stop and finish.**
  - `S_STP1` (SDA low), `S_STP2` (SCL high) and `S_STP3` (SDA high, the STOP) lead to `S_FIN`.
  - `S_FIN` holds the bus free for one tick.
  - From there it either retries via `S_STA1` or returns to `S_IDLE` with the done pulse.

Top module: `eep_byte_master`

## Requirements
- R1: After reset SCL is high, SDA is released (sda_drive_low = 0), and busy, done and err are 0.
- R2: Each transaction begins with a START: SDA is high and SCL is raised, then SDA falls while SCL stays high, one tick per step.
- R3: Apart from START and STOP, SDA changes only while SCL is low. Slaves sample on the SCL rising edge, and bytes go MSB first.
- R4: A write (rd_nwr = 0) puts START, 0xA0, addr[7:0], wdata, STOP on the bus. Each byte is followed by a ninth clock in which SDA low means ACK. STOP comes only after the third ACK.
- R5: A read (rd_nwr = 1) puts START, 0xA0, addr[7:0], a repeated START (no STOP), 0xA1 on the bus. It then clocks in 8 bits MSB first. SDA is left high in the ninth clock (no acknowledge), and STOP follows. The received byte appears on rdata in the cycle done is high.
- R6: An SCL high phase of a data bit lasts tick_count + 1 clock cycles. A tick_count below 10 is treated as 10, giving 11 cycles.
- R7: addr[8] is driven on ce_hi for the whole transaction. The select bytes stay 0xA0 and 0xA1 whatever addr[8] is.
- R8: A NACK (SDA high in a ninth clock of a byte sent by the master) ends the attempt with a STOP, and the whole transaction restarts with a new START. At most 4 attempts are made. If all of them fail, done is raised with err = 1 and no data byte is written.
- R9: done is a one-cycle pulse that ends each transaction. busy is 1 from the cycle after the request until done. err is 0 when the transaction succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a transaction (taken while idle) |
| rd_nwr | input | 1 | 1 = random read, 0 = byte write |
| addr | input | 9 | Byte address; bit 8 selects the upper half |
| wdata | input | 8 | Byte to write |
| tick_count | input | 8 | Timer reload count (10..255) pacing each bus phase |
| rdata | output | 8 | Byte returned by the last successful read |
| done | output | 1 | One-cycle end-of-transaction pulse |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Transaction abandoned after 4 NACKed attempts (valid with done) |
| ce_hi | output | 1 | Upper-half chip-enable, copy of addr[8] |
| scl | output | 1 | Serial clock |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
A wrong bit counter or byte index shows up at the slave model as a wrong byte value or a misplaced START or STOP. It appears within the frame in which it goes wrong, which is at most 27 ticks. A stale abort flag or try counter shows up as extra or missing restart sequences on the bus, and err is wrong at the done pulse. A wrong receive shift register shows up as a wrong rdata in the done cycle. A fault in the tick generator changes the measured SCL high time of the very next bit.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int EEP_AW = 9;
    localparam int EEP_DW = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STA1,
        S_STA2,
        S_STA3,
        S_STA4,
        S_BLO,
        S_BHI,
        S_BHOLD,
        S_STP1,
        S_STP2,
        S_STP3,
        S_FIN
    } eep_state_e;
endpackage

// File: rtl/eep_tick.sv
module eep_tick #(
    parameter int CW      = 8,
    parameter int MIN_CNT = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    output logic          tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] load;

    // counts below the minimum are raised to it
    assign load = (count < CW'(MIN_CNT)) ? CW'(MIN_CNT) : count;
    assign tick = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (tick)   cnt <= load;
        else             cnt <= cnt - 1'b1;
    end

    // R6: tick period is load+1 >= 11 cycles, so ticks never come back to back
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/eep_seq.sv
module eep_seq
    import eep_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         MAX_TRY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic              rd_nwr,
    input  logic [EEP_AW-1:0] addr,
    input  logic [EEP_DW-1:0] wdata,
    output logic [EEP_DW-1:0] rdata,
    output logic              done,
    output logic              busy,
    output logic              err,
    output logic              ce_hi,
    output logic              scl,
    output logic              sda_low,
    input  logic              sda_in
);
    localparam int TW = $clog2(MAX_TRY + 1);

    eep_state_e        state;
    logic              is_rd;
    logic [EEP_DW-1:0] adr_lo;
    logic [EEP_DW-1:0] wd;
    logic [1:0]        idx;
    logic [3:0]        bitn;
    logic [EEP_DW-1:0] rx;
    logic              nack_seen;
    logic              aborted;
    logic [TW-1:0]     tries;
    logic [EEP_DW-1:0] tx_byte;
    logic              receiving;
    logic              last_byte;

    always_comb begin
        unique case (idx)
            2'd0:    tx_byte = {DEV_ADDR, 1'b0};
            2'd1:    tx_byte = adr_lo;
            2'd2:    tx_byte = is_rd ? {DEV_ADDR, 1'b1} : wd;
            default: tx_byte = '1;
        endcase
    end

    assign receiving = is_rd && (idx == 2'd3);
    assign last_byte = is_rd ? (idx == 2'd3) : (idx == 2'd2);

    // output process: bus levels decoded from the state
    always_comb begin
        scl     = 1'b1;
        sda_low = 1'b0;
        unique case (state)
            S_IDLE, S_FIN: begin scl = 1'b1; sda_low = 1'b0; end
            S_STA1:        begin scl = 1'b0; sda_low = 1'b0; end
            S_STA2:        begin scl = 1'b1; sda_low = 1'b0; end
            S_STA3:        begin scl = 1'b1; sda_low = 1'b1; end
            S_STA4:        begin scl = 1'b0; sda_low = 1'b1; end
            S_BLO, S_BHI, S_BHOLD: begin
                scl     = (state == S_BHI);
                sda_low = !receiving && !bitn[3] && !tx_byte[~bitn[2:0]];
            end
            S_STP1:        begin scl = 1'b0; sda_low = 1'b1; end
            S_STP2:        begin scl = 1'b1; sda_low = 1'b1; end
            S_STP3:        begin scl = 1'b1; sda_low = 1'b0; end
        endcase
    end

    // state register with its sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            is_rd     <= 1'b0;
            adr_lo    <= '0;
            wd        <= '0;
            ce_hi     <= 1'b0;
            idx       <= '0;
            bitn      <= '0;
            rx        <= '0;
            rdata     <= '0;
            nack_seen <= 1'b0;
            aborted   <= 1'b0;
            tries     <= '0;
            done      <= 1'b0;
            busy      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == S_IDLE) begin
                if (req) begin
                    is_rd   <= rd_nwr;
                    adr_lo  <= addr[EEP_DW-1:0];
                    ce_hi   <= addr[EEP_AW-1];
                    wd      <= wdata;
                    idx     <= '0;
                    tries   <= TW'(1);
                    aborted <= 1'b0;
                    busy    <= 1'b1;
                    err     <= 1'b0;
                    state   <= S_STA1;
                end
            end else if (tick) begin
                unique case (state)
                    S_STA1: state <= S_STA2;
                    S_STA2: state <= S_STA3;
                    S_STA3: state <= S_STA4;
                    S_STA4: begin
                        bitn  <= '0;
                        state <= S_BLO;
                    end
                    S_BLO:  state <= S_BHI;
                    S_BHI: begin
                        if (bitn[3])        nack_seen <= sda_in;
                        else if (receiving) rx <= {rx[EEP_DW-2:0], sda_in};
                        state <= S_BHOLD;
                    end
                    S_BHOLD: begin
                        if (!bitn[3]) begin
                            bitn  <= bitn + 4'd1;
                            state <= S_BLO;
                        end else if (!receiving && nack_seen) begin
                            aborted <= 1'b1;
                            state   <= S_STP1;
                        end else if (last_byte) begin
                            state <= S_STP1;
                        end else if (is_rd && idx == 2'd1) begin
                            idx   <= 2'd2;
                            state <= S_STA1;
                        end else begin
                            idx   <= idx + 2'd1;
                            bitn  <= '0;
                            state <= S_BLO;
                        end
                    end
                    S_STP1: state <= S_STP2;
                    S_STP2: state <= S_STP3;
                    S_STP3: state <= S_FIN;
                    S_FIN: begin
                        if (aborted && tries < TW'(MAX_TRY)) begin
                            tries   <= tries + 1'b1;
                            aborted <= 1'b0;
                            idx     <= '0;
                            state   <= S_STA1;
                        end else begin
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            err   <= aborted;
                            if (!aborted && is_rd) rdata <= rx;
                            state <= S_IDLE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R3: SDA moves under a high SCL only to form START or STOP
    p_sda_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && (sda_low != $past(sda_low))) |->
            (state == S_STA3 || state == S_STP3));

    // R9: done lasts one cycle and coincides with busy low
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: attempts are capped and err only appears with done
    p_try_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tries <= TW'(MAX_TRY)));
    p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
endmodule

// File: rtl/eep_byte_master.sv
module eep_byte_master
    import eep_pkg::*;
#(
    parameter int         CNT_W    = 8,
    parameter int         MIN_CNT  = 10,
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         MAX_TRY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rd_nwr,
    input  logic [EEP_AW-1:0] addr,
    input  logic [EEP_DW-1:0] wdata,
    input  logic [CNT_W-1:0]  tick_count,
    output logic [EEP_DW-1:0] rdata,
    output logic              done,
    output logic              busy,
    output logic              err,
    output logic              ce_hi,
    output logic              scl,
    output logic              sda_drive_low,
    input  logic              sda_in
);
    logic tick;

    eep_tick #(.CW(CNT_W), .MIN_CNT(MIN_CNT)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tick_count),
        .tick  (tick)
    );

    eep_seq #(.DEV_ADDR(DEV_ADDR), .MAX_TRY(MAX_TRY)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .req     (req),
        .rd_nwr  (rd_nwr),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .done    (done),
        .busy    (busy),
        .err     (err),
        .ce_hi   (ce_hi),
        .scl     (scl),
        .sda_low (sda_drive_low),
        .sda_in  (sda_in)
    );
endmodule

// File: tb/test_eep_byte_master.sv
module test_eep_byte_master;
    localparam int CLK_PERIOD = 10;
    localparam int EV_START   = 1000;
    localparam int EV_STOP    = 1001;
    localparam int EV_MBIT    = 3000;
    localparam int WD_LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       rd_nwr = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] tick_count = 8'd10;
    logic [7:0] rdata;
    logic       done, busy, err, ce_hi, scl, m_low;
    logic       s_low = 1'b0;
    logic       sda_bus;

    assign sda_bus = !(m_low || s_low);

    eep_byte_master i_eep_byte_master (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_nwr(rd_nwr), .addr(addr),
        .wdata(wdata), .tick_count(tick_count), .rdata(rdata), .done(done),
        .busy(busy), .err(err), .ce_hi(ce_hi), .scl(scl),
        .sda_drive_low(m_low), .sda_in(sda_bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int sb_checks = 0;
    int sb_fails  = 0;
    int exp_q[$];

    task automatic note(input string tag, input bit ok, input int act, input int expv);
        sb_checks++;
        if (!ok) begin
            sb_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic see_event(input int ev);
        int e;
        if (exp_q.size() == 0) begin
            note("R2 R4 R5 R8 unexpected bus event", 1'b0, ev, -1);
        end else begin
            e = exp_q.pop_front();
            note("R2 R4 R5 R8 bus event", ev == e, ev, e);
        end
    endtask

    // slave EEPROM model acting as the scoreboard monitor
    logic [7:0] mem [512];
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic       cur_scl, cur_sda;
    int         k = 0, fidx = 0, hi_len = 0, last_hi = 0;
    bit         stx = 0, acked = 0;
    logic [7:0] sh = '0, ptr = '0, obyte = '0;
    int         nack_at = -1, nack_left = 0;

    always @(negedge clk) begin
        cur_scl = scl;
        cur_sda = sda_bus;
        if (cur_scl) hi_len++;
        if (p_scl && cur_scl && p_sda && !cur_sda) begin
            see_event(EV_START);
            k = 0; stx = 0; fidx = 0; s_low = 1'b0;
        end else if (p_scl && cur_scl && !p_sda && cur_sda) begin
            see_event(EV_STOP);
            k = 0; stx = 0; s_low = 1'b0;
        end else if (!p_scl && cur_scl) begin
            hi_len = 1;
            if (!stx && k < 8) sh = {sh[6:0], cur_sda};
            if (stx && k == 8) see_event(EV_MBIT + int'(cur_sda));
            k++;
            if (!stx && k == 8) see_event(int'(sh));
        end else if (p_scl && !cur_scl) begin
            last_hi = hi_len;
            if (!stx) begin
                if (k == 8) begin
                    acked = !(fidx == nack_at && nack_left > 0);
                    if (!acked) nack_left--;
                    s_low = acked;
                end else if (k == 9) begin
                    s_low = 1'b0;
                    k = 0;
                    if (acked) begin
                        if (fidx == 0 && sh == 8'hA1) begin
                            stx   = 1;
                            obyte = mem[{ce_hi, ptr}];
                            s_low = !obyte[7];
                        end
                        if (fidx == 1) ptr = sh;
                        if (fidx == 2) mem[{ce_hi, ptr}] = sh;
                    end
                    fidx++;
                end
            end else begin
                if (k < 8)       s_low = !obyte[7-k];
                else if (k == 8) s_low = 1'b0;
                else begin k = 0; stx = 0; end
            end
        end
        p_scl = cur_scl;
        p_sda = cur_sda;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            note("R9 watchdog expired", 1'b0, cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", sb_checks, sb_fails);
            $finish;
        end
    end

    // driver: pushes the expected bus events, then issues the request
    task automatic run_txn(input bit rd, input logic [8:0] a, input logic [7:0] d,
                           input int nframe, input int nacks, input logic [7:0] exp_rd,
                           input string tag);
        int nfail;
        nfail = (nacks > 4) ? 4 : nacks;
        for (int i = 0; i < nfail; i++) begin
            exp_q.push_back(EV_START);
            exp_q.push_back(8'hA0);
            if (nframe >= 1) exp_q.push_back(int'(a[7:0]));
            exp_q.push_back(EV_STOP);
        end
        if (nacks < 4) begin
            exp_q.push_back(EV_START);
            exp_q.push_back(8'hA0);
            exp_q.push_back(int'(a[7:0]));
            if (rd) begin
                exp_q.push_back(EV_START);
                exp_q.push_back(8'hA1);
                exp_q.push_back(EV_MBIT + 1);
            end else begin
                exp_q.push_back(int'(d));
            end
            exp_q.push_back(EV_STOP);
        end
        nack_at   = nframe;
        nack_left = nacks;
        @(negedge clk);
        req = 1'b1; rd_nwr = rd; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        note({tag, " R9 busy after request"}, busy == 1'b1, busy, 1);
        note({tag, " R7 chip enable"}, ce_hi == a[8], ce_hi, a[8]);
        while (!done) @(negedge clk);
        note({tag, " R8 R9 err at done"}, err == (nacks >= 4), err, nacks >= 4);
        note({tag, " R9 busy low at done"}, busy == 1'b0, busy, 0);
        if (rd && nacks < 4) note({tag, " R5 read data"}, rdata == exp_rd, rdata, exp_rd);
        note({tag, " R4 R5 R8 all bus events seen"}, exp_q.size() == 0, exp_q.size(), 0);
        @(negedge clk);
        note({tag, " R9 done pulse one cycle"}, done == 1'b0, done, 0);
        nack_at   = -1;
        nack_left = 0;
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'h55;
        mem[9'h0A5] = 8'h5A;
        repeat (3) @(negedge clk);
        note("R1 scl after reset", scl == 1'b1, scl, 1);
        note("R1 sda after reset", m_low == 1'b0, m_low, 0);
        note("R1 busy/done/err after reset", {busy, done, err} == 3'b000, {busy, done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        tick_count = 8'd10;
        run_txn(1'b0, 9'h005, 8'h3C, -1, 0, 8'h00, "write low");
        note("R4 byte stored", mem[9'h005] == 8'h3C, mem[9'h005], 8'h3C);
        note("R6 scl high length count 10", last_hi == 11, last_hi, 11);
        run_txn(1'b1, 9'h005, 8'h00, -1, 0, 8'h3C, "read low");

        run_txn(1'b0, 9'h1A5, 8'h81, -1, 0, 8'h00, "write upper");
        note("R7 upper byte stored", mem[9'h1A5] == 8'h81, mem[9'h1A5], 8'h81);
        note("R7 lower twin untouched", mem[9'h0A5] == 8'h5A, mem[9'h0A5], 8'h5A);
        run_txn(1'b1, 9'h0A5, 8'h00, -1, 0, 8'h5A, "read lower twin");
        run_txn(1'b1, 9'h1A5, 8'h00, -1, 0, 8'h81, "read upper");

        run_txn(1'b0, 9'h010, 8'h77, 1, 1, 8'h00, "R8 write addr nack once");
        note("R8 byte stored after retry", mem[9'h010] == 8'h77, mem[9'h010], 8'h77);
        run_txn(1'b1, 9'h005, 8'h00, 0, 2, 8'h3C, "R8 read select nack twice");

        run_txn(1'b0, 9'h020, 8'hEE, 0, 100, 8'h00, "R8 write always nack");
        note("R8 no write after give-up", mem[9'h020] == (8'h20 ^ 8'h55), mem[9'h020], 8'h20 ^ 8'h55);
        run_txn(1'b0, 9'h021, 8'hC3, -1, 0, 8'h00, "R9 success clears err");

        tick_count = 8'd4;
        run_txn(1'b0, 9'h0FF, 8'hA5, -1, 0, 8'h00, "R6 clamp");
        note("R6 scl high length clamped", last_hi == 11, last_hi, 11);
        tick_count = 8'd20;
        run_txn(1'b1, 9'h0FF, 8'h00, -1, 0, 8'hA5, "R6 slow read");
        note("R6 scl high length count 20", last_hi == 21, last_hi, 21);

        $display("End of test - %0d assertions evaluated, %0d failures", sb_checks, sb_fails);
        $finish;
    end
endmodule